// File: doc/BRIEF.md
# Mode-3 SPI Slave with Not-Ready Filler

This block is the serial-port end of a peripheral that answers a host over a four-wire SPI link with clock polarity 1 and phase 1. The host drops the active-low enable, then clocks bytes most significant bit first. The slave samples the data-in line on rising clock edges and changes the data-out line on falling edges. Every complete byte received other than all ones is handed to the core on a one-cycle command strobe. All-ones bytes are the dummies a host clocks in while it only wants to read, so they are dropped.

Response bytes come from a producer through a valid/pop handshake. A byte is taken from the producer when the enable falls, or when a byte boundary passes with the enable still low. If the producer has nothing ready at that moment, the slave shifts out an all-ones filler byte. The host can therefore poll until a byte other than the filler comes back. The data-out line is always driven to a defined level and keeps its last value while the enable is high.

All four pins are asynchronous to the system clock. They pass through two-flop synchronisers, and edges are found on the synchronised levels. For this to work, the system clock must run several times faster than the serial clock.

Top module: `spi3_fill_slave`

## Requirements
- R1: While reset is high and right after it is released, `sdo` is 1 and `cmd_valid` and `rsp_pop` are 0.
- R2: The response byte's bit 7 is on `sdo` before the first falling `sclk` edge of a byte. Each later falling edge inside the byte moves to the next lower bit, so the host reads the byte MSB first on rising edges.
- R3: `sdi` is shifted in MSB first on rising `sclk` edges while `en_n` is low. After the eighth rising edge, a byte other than 0xFF is presented on `cmd_data` with `cmd_valid` high for exactly one clock cycle.
- R4: A received byte equal to 0xFF raises no command strobe.
- R5: If `rsp_valid` is low when a response byte is loaded, the slave sends 0xFF and does not pulse `rsp_pop`.
- R6: Each load that takes a producer byte pulses `rsp_pop` for one cycle. Producer bytes reach `sdo` in order, each exactly once, across byte boundaries and across enable windows. A byte loaded at the last boundary of a window is kept for the next window.
- R7: While `en_n` is high, activity on `sclk` and `sdi` changes neither `sdo` nor the bit position, and raises neither strobe.
- R8: If `en_n` rises in the middle of a byte, the partial byte is discarded with no command strobe, and the next window starts again at bit 7.
- R9: `sdo` is driven to 0 or 1 on every cycle after reset, including while `en_n` is high.
- R10: A filler byte held from a boundary is replaced at the next enable fall by a producer byte if one is valid then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low enable from the host (asynchronous) |
| sclk | input | 1 | Serial clock from the host, idles high (asynchronous) |
| sdi | input | 1 | Serial data from the host (asynchronous) |
| sdo | output | 1 | Serial data to the host, always driven |
| cmd_valid | output | 1 | One-cycle strobe for a received command byte |
| cmd_data | output | 8 | Received command byte |
| rsp_valid | input | 1 | Producer has a response byte ready |
| rsp_data | input | 8 | Response byte from the producer |
| rsp_pop | output | 1 | One-cycle strobe: response byte taken |

## Verification
The embedded properties check on every cycle that both strobes are single-cycle pulses, and that no pop happens without a valid byte offered. They also check that an all-ones byte never appears on the command strobe, that `sdo` is never unknown, and that nothing moves on `sdo` or the strobes while the synchronised enable is high. Bit order, the filler on an empty producer, hand-over of a held byte across enable windows, the replacement of a held filler, and recovery after an aborted byte depend on sequences of host transfers. Only the bench scenarios show those. In them, a sweep of all 256 command values runs against a stream of computed response bytes.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  // Default byte width of the serial link.
  localparam int unsigned SPI3_BYTE_W = 8;
  // Number of flops in each pin synchroniser chain.
  localparam int unsigned SPI3_SYNC_STAGES = 2;

  // Where the transmit shift register takes its next byte from.
  typedef enum logic [1:0] {
    TX_SRC_NONE = 2'd0,
    TX_SRC_PROD = 2'd1,
    TX_SRC_FILL = 2'd2
  } tx_src_e;
endpackage

// File: rtl/spi3_pin_sync.sv
module spi3_pin_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  localparam int unsigned CHAIN = STAGES + 1;

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic [CHAIN-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {CHAIN{RST_VAL[g]}};
      else     chain <= {chain[CHAIN-2:0], din[g]};
    end
    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
    assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/spi3_rx_deser.sv
module spi3_rx_deser #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_act,
  input  logic         sclk_rise,
  input  logic         sdi_s,
  output logic         byte_end,
  output logic         idx_zero,
  output logic         cmd_valid,
  output logic [W-1:0] cmd_data
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [W-1:0] DUMMY = '1;

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic [W-1:0]  nb;

  assign nb       = {sh[W-2:0], sdi_s};
  assign byte_end = en_act && sclk_rise && (cnt == LAST);
  assign idx_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sh        <= '0;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (!en_act) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        sh <= nb;
        if (cnt == LAST) begin
          cnt <= '0;
          if (nb != DUMMY) begin
            cmd_valid <= 1'b1;
            cmd_data  <= nb;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid) else $error("cmd strobe longer than one cycle"); // R3
  AST_NO_DUMMY_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_data != DUMMY)) else $error("all-ones byte strobed"); // R4
endmodule

// File: rtl/spi3_tx_ser.sv
module spi3_tx_ser
  import spi3_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_act,
  input  logic         en_fall,
  input  logic         sclk_fall,
  input  logic         byte_end,
  input  logic         idx_zero,
  input  logic         rsp_valid,
  input  logic [W-1:0] rsp_data,
  output logic         sdo,
  output logic         rsp_pop
);
  localparam logic [W-1:0] FILL = '1;

  logic [W-1:0] sh;
  logic         fresh;
  logic         held_real;
  tx_src_e      src;

  always_comb begin
    src = TX_SRC_NONE;
    if (byte_end || (en_fall && !(fresh && held_real)))
      src = rsp_valid ? TX_SRC_PROD : TX_SRC_FILL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= FILL;
      fresh     <= 1'b0;
      held_real <= 1'b0;
      rsp_pop   <= 1'b0;
    end else begin
      rsp_pop <= 1'b0;
      case (src)
        TX_SRC_PROD: begin
          sh        <= rsp_data;
          rsp_pop   <= 1'b1;
          held_real <= 1'b1;
          fresh     <= 1'b1;
        end
        TX_SRC_FILL: begin
          sh        <= FILL;
          held_real <= 1'b0;
          fresh     <= 1'b1;
        end
        default: begin
          if (en_act && sclk_fall && !idx_zero) begin
            sh    <= {sh[W-2:0], 1'b1};
            fresh <= 1'b0;
          end
        end
      endcase
    end
  end

  assign sdo = sh[W-1];

  AST_POP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_pop |=> !rsp_pop) else $error("pop longer than one cycle"); // R6
  AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    rsp_pop |-> $past(rsp_valid)) else $error("pop without valid"); // R5
  AST_SDO_KNOWN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(sdo)) else $error("sdo unknown"); // R9
  AST_SDO_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!en_act) |-> $stable(sdo)) else $error("sdo moved while idle"); // R7
endmodule

// File: rtl/spi3_fill_slave.sv
module spi3_fill_slave
  import spi3_pkg::*;
#(
  parameter int unsigned BYTE_W = SPI3_BYTE_W,
  parameter int unsigned SYNC_STAGES = SPI3_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_data,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data,
  output logic              rsp_pop
);
  localparam int unsigned NPIN = 3;
  localparam int unsigned P_EN = 2;
  localparam int unsigned P_SCK = 1;
  localparam int unsigned P_SDI = 0;

  logic [NPIN-1:0] pin_lvl, pin_rise, pin_fall;
  logic            en_act, byte_end, idx_zero;
  logic [3:0]      sync_unused;

  spi3_pin_sync #(
    .W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL('1)
  ) u_sync (
    .clk(clk), .rst(rst),
    .din({en_n, sclk, sdi}),
    .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  assign en_act      = ~pin_lvl[P_EN];
  assign sync_unused = {pin_rise[P_EN], pin_rise[P_SDI], pin_fall[P_SDI], pin_lvl[P_SCK]};

  spi3_rx_deser #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst),
    .en_act(en_act), .sclk_rise(pin_rise[P_SCK]), .sdi_s(pin_lvl[P_SDI]),
    .byte_end(byte_end), .idx_zero(idx_zero),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data)
  );

  spi3_tx_ser #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst),
    .en_act(en_act), .en_fall(pin_fall[P_EN]), .sclk_fall(pin_fall[P_SCK]),
    .byte_end(byte_end), .idx_zero(idx_zero),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sdo(sdo), .rsp_pop(rsp_pop)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(pin_lvl[P_EN]) |-> (!cmd_valid && !rsp_pop)) else $error("strobe while idle"); // R7
endmodule

// File: tb/tb_spi3_fill_slave.sv
module tb_spi3_fill_slave;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_n = 1'b1, sclk = 1'b1, sdi = 1'b1;
  logic       sdo, cmd_valid, rsp_pop, rsp_valid;
  logic [7:0] cmd_data, rsp_data;

  logic [7:0] prod_q [0:511];
  int         prod_n = 0, prod_rd = 0;
  logic [7:0] cmd_log [0:511];
  int         cmd_n = 0;
  int         n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  assign rsp_valid = (prod_rd < prod_n);
  assign rsp_data  = prod_q[prod_rd[8:0]];

  spi3_fill_slave dut (
    .clk(clk), .rst(rst), .en_n(en_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_pop(rsp_pop)
  );

  always @(posedge clk) begin
    if (rsp_pop) prod_rd <= prod_rd + 1;
    if (cmd_valid) begin
      cmd_log[cmd_n[8:0]] <= cmd_data;
      cmd_n <= cmd_n + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    prod_q[prod_n[8:0]] = b;
    prod_n++;
  endtask

  task automatic en_lo();
    en_n = 1'b0; wait_cyc(HALF);
  endtask

  task automatic en_hi();
    en_n = 1'b1; wait_cyc(HALF);
  endtask

  // Clock nbits bits MSB first; sample sdo at the end of each low phase.
  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0; sdi = tx[7-i];
      wait_cyc(HALF);
      rx[7-i] = sdo;
      sclk = 1'b1;
      wait_cyc(HALF);
    end
    sdi = 1'b1;
  endtask

  function automatic logic [7:0] pval(input int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    int c0, p0, bad;
    wait_cyc(4);
    chk("R1 sdo in reset", int'(sdo), 1);
    rst = 1'b0;
    wait_cyc(2);
    chk("R1 sdo after reset", int'(sdo), 1);
    chk("R1 cmd_valid after reset", int'(cmd_valid), 0);
    chk("R1 rsp_pop after reset", int'(rsp_pop), 0);

    // R5: empty producer gives filler, command still received (R3)
    en_lo(); xfer(8'h35, 8, rx); en_hi();
    chk("R5 filler byte", int'(rx), 'hFF);
    chk("R5 no pop", prod_rd, 0);
    chk("R3 first command count", cmd_n, 1);
    chk("R3 first command value", int'(cmd_log[0]), 'h35);

    // R2/R3/R4/R6 sweep: all commands, bursts of four bytes per window
    for (int i = 0; i < 256; i++) push(pval(i));
    bad = 0;
    for (int b = 0; b < 64; b++) begin
      en_lo();
      for (int k = 0; k < 4; k++) begin
        xfer(8'(b * 4 + k), 8, rx);
        if (rx !== pval(b * 4 + k)) begin
          bad++;
          $display("FAIL R2 byte %0d: actual %h expected %h", b * 4 + k, rx, pval(b * 4 + k));
        end
      end
      en_hi();
    end
    n_chk++; if (bad != 0) n_err++;
    chk("R6 every produced byte popped once", prod_rd, 256);
    chk("R4 command count skips all-ones", cmd_n, 256);
    bad = 0;
    for (int i = 0; i < 255; i++)
      if (cmd_log[i + 1] !== 8'(i)) bad++;
    chk("R3 command sequence mismatches", bad, 0);

    // R10: filler held at boundary is replaced at enable fall
    en_lo(); xfer(8'hFF, 8, rx); en_hi();
    chk("R5 filler when drained", int'(rx), 'hFF);
    push(8'hC3);
    en_lo(); xfer(8'hFF, 8, rx); en_hi();
    chk("R10 held filler replaced", int'(rx), 'hC3);
    chk("R4 dummies not strobed", cmd_n, 256);

    // R7: held real byte survives clocking while enable is high
    push(8'h5A); push(8'h96);
    en_lo(); xfer(8'h10, 8, rx); en_hi();
    chk("R6 first of pair", int'(rx), 'h5A);
    c0 = cmd_n; p0 = prod_rd;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdi = i[0]; wait_cyc(HALF);
      sclk = 1'b1; wait_cyc(HALF);
    end
    sdi = 1'b1;
    chk("R7 no command while idle", cmd_n, c0);
    chk("R7 no pop while idle", prod_rd, p0);
    chk("R9 sdo driven while idle", int'(sdo === 1'b1), 1);
    en_lo(); xfer(8'hFF, 8, rx); en_hi();
    chk("R7 held byte intact", int'(rx), 'h96);

    // R8: aborted partial byte
    push(8'h81); push(8'h7E);
    c0 = cmd_n;
    en_lo(); xfer(8'hA0, 3, rx); en_hi();
    chk("R2 partial bits", int'(rx[7:5]), 'b100);
    chk("R8 no strobe on abort", cmd_n, c0);
    en_lo(); xfer(8'h42, 8, rx); en_hi();
    chk("R8 next byte after abort", int'(rx), 'h7E);
    chk("R8 realigned command", int'(cmd_log[c0[8:0]]), 'h42);
    chk("R8 command count", cmd_n, c0 + 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule